// File: doc/BRIEF.md
# Execute Redirect and Squash Generator

This block sits at the tail of an out-of-order execute stage. Each cycle it examines the group of instructions that finished execution, ordered oldest (slot 0) to youngest, and decides for every hardware thread whether the front end must be redirected. It then hands a registered squash record to the commit stage for each such thread. Three events can cause a squash. The first is a branch that resolved against its prediction. The second is a memory-ordering violation that the load/store queue has flagged for a thread. The third is a load that the memory system refused and that has not been dealt with yet.

Each cause fills the squash record differently. A branch or ordering squash restarts after the offending instruction and spares that instruction. A blocked-load squash restarts at the load itself and kills it too. Per thread, only the oldest qualifying instruction in the group wins. Everything younger on that thread is ignored, because the squash removes it anyway. Three running counters record taken and not-taken mispredicts and ordering violations.

Top module: `exec_redirect_gen`

## Requirements
- R1: After reset all record valid bits, acknowledge pulses and counters read zero.
- R2: A valid, non-squashed slot with its mispredict flag set gives its thread a record the next cycle with cause code 1, the slot's sequence number, the mispredicted PC equal to the slot's PC, a restart PC equal to its next PC, and include-self 0.
- R3: On a cause-1 record the taken bit is 1 exactly when the next PC differs from PC + INST_BYTES (4 by default). On other causes the taken bit is 0.
- R4: A memory slot whose thread has its ordering-violation input high gives cause code 2, with restart PC equal to the next PC, include-self 0 and mispredicted PC 0.
- R5: A memory slot whose thread has a live load-blocked input gives cause code 3, with restart PC equal to the slot's own PC and include-self 1. It also raises that thread's acknowledge output for exactly the cycle the record is valid.
- R6: After a blocked-load squash, that thread's load-blocked input has no further effect while it stays high. Once it has been low for one cycle it is live again.
- R7: Within one slot the causes are ranked mispredict, then ordering violation, then blocked load.
- R8: Each thread takes only the lowest-numbered qualifying slot of its own thread. Threads are independent of one another.
- R9: Slots that are not valid, or that are marked squashed, never produce a record.
- R10: Each accepted record adds one to exactly one of the counters. A cause-1 record counts as predicted-taken-wrong if its slot had the predicted-taken flag set, and as predicted-not-taken-wrong otherwise. A cause-2 record counts as an ordering event. Cause-3 records are not counted, and a cycle with no record leaves all counters unchanged.
- R11: A record is valid for one cycle only. A cycle with no qualifying slot gives no valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ex_valid_i | input | W | Slot holds a finished instruction |
| ex_squashed_i | input | W | Slot instruction already squashed |
| ex_mem_i | input | W | Slot is a memory reference |
| ex_tid_i | input | W*TID_W | Thread of each slot |
| ex_seq_i | input | W*SEQ_W | Sequence number of each slot |
| ex_pc_i | input | W*PC_W | PC of each slot |
| ex_npc_i | input | W*PC_W | Resolved next PC of each slot |
| ex_mispred_i | input | W | Branch resolved against prediction |
| ex_pred_taken_i | input | W | Branch was predicted taken |
| order_viol_i | input | T | Per-thread ordering violation flag |
| ld_blk_i | input | T | Per-thread blocked-load flag |
| sq_valid_o | output | T | Squash record valid |
| sq_cause_o | output | T*2 | Cause code per thread |
| sq_incl_self_o | output | T | Squash includes the instruction itself |
| sq_taken_o | output | T | Resolved branch direction |
| sq_seq_o | output | T*SEQ_W | Sequence number of squashing instruction |
| sq_restart_pc_o | output | T*PC_W | PC to refetch from |
| sq_mispc_o | output | T*PC_W | PC of mispredicted branch |
| ld_blk_ack_o | output | T | Blocked load handled, one-cycle pulse |
| cnt_taken_bad_o | output | CNT_W | Mispredicts of predicted-taken branches |
| cnt_nt_bad_o | output | CNT_W | Mispredicts of predicted-not-taken branches |
| cnt_order_o | output | CNT_W | Ordering violation events |

## Verification
The assertions assume that the load/store queue keeps a thread's blocked-load flag high until it has seen the acknowledge. They also assume the counters never wrap during a run. The stimulus raises each flag only around the cycles of the scenario that uses it. It holds the blocked flag across the acknowledge, drops it for one cycle before re-arming, and keeps the event totals far below the counter range. Thread numbers are always below the thread count.

// File: rtl/exr_pkg.sv
package exr_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_ORDER  = 2'd2,
    CAUSE_LDBLK  = 2'd3
  } cause_e;
endpackage

// File: rtl/exr_slot_decode.sv
module exr_slot_decode
  import exr_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1,
  parameter int PC_W        = 32,
  parameter int INST_BYTES  = 4
) (
  input  logic                   valid_i,
  input  logic                   squashed_i,
  input  logic                   mem_i,
  input  logic                   mispred_i,
  input  logic [TID_W-1:0]       tid_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [PC_W-1:0]        npc_i,
  input  logic [NUM_THREADS-1:0] order_viol_i,
  input  logic [NUM_THREADS-1:0] ld_blk_live_i,
  output cause_e                 cause_o,
  output logic                   dir_taken_o
);
  assign dir_taken_o = (npc_i != (pc_i + PC_W'(INST_BYTES)));

  // fixed ranking: branch, ordering, blocked load
  always_comb begin
    cause_o = CAUSE_NONE;
    if (valid_i && !squashed_i) begin
      if (mispred_i)                         cause_o = CAUSE_BRANCH;
      else if (mem_i && order_viol_i[tid_i])  cause_o = CAUSE_ORDER;
      else if (mem_i && ld_blk_live_i[tid_i]) cause_o = CAUSE_LDBLK;
    end
  end
endmodule

// File: rtl/exr_thread_pick.sv
module exr_thread_pick
  import exr_pkg::*;
#(
  parameter int W         = 4,
  parameter int TID_W     = 1,
  parameter int THREAD_ID = 0,
  localparam int IDX_W    = (W > 1) ? $clog2(W) : 1
) (
  input  cause_e           cause_i [W],
  input  logic [TID_W-1:0] tid_i   [W],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // oldest slot of this thread with a cause wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int s = 0; s < W; s++) begin
      if (!hit_o && cause_i[s] != CAUSE_NONE && tid_i[s] == TID_W'(THREAD_ID)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/exr_evt_counter.sv
module exr_evt_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/exec_redirect_gen.sv
module exec_redirect_gen
  import exr_pkg::*;
#(
  parameter int W           = 4,
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int INST_BYTES  = 4,
  parameter int CNT_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W      = (W > 1) ? $clog2(W) : 1,
  localparam int INC_W      = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [W-1:0]                 ex_valid_i,
  input  logic [W-1:0]                 ex_squashed_i,
  input  logic [W-1:0]                 ex_mem_i,
  input  logic [W*TID_W-1:0]           ex_tid_i,
  input  logic [W*SEQ_W-1:0]           ex_seq_i,
  input  logic [W*PC_W-1:0]            ex_pc_i,
  input  logic [W*PC_W-1:0]            ex_npc_i,
  input  logic [W-1:0]                 ex_mispred_i,
  input  logic [W-1:0]                 ex_pred_taken_i,
  input  logic [NUM_THREADS-1:0]       order_viol_i,
  input  logic [NUM_THREADS-1:0]       ld_blk_i,
  output logic [NUM_THREADS-1:0]       sq_valid_o,
  output logic [NUM_THREADS*2-1:0]     sq_cause_o,
  output logic [NUM_THREADS-1:0]       sq_incl_self_o,
  output logic [NUM_THREADS-1:0]       sq_taken_o,
  output logic [NUM_THREADS*SEQ_W-1:0] sq_seq_o,
  output logic [NUM_THREADS*PC_W-1:0]  sq_restart_pc_o,
  output logic [NUM_THREADS*PC_W-1:0]  sq_mispc_o,
  output logic [NUM_THREADS-1:0]       ld_blk_ack_o,
  output logic [CNT_W-1:0]             cnt_taken_bad_o,
  output logic [CNT_W-1:0]             cnt_nt_bad_o,
  output logic [CNT_W-1:0]             cnt_order_o
);
  // slot views
  logic [TID_W-1:0] slot_tid  [W];
  logic [SEQ_W-1:0] slot_seq  [W];
  logic [PC_W-1:0]  slot_pc   [W];
  logic [PC_W-1:0]  slot_npc  [W];
  cause_e           slot_cause[W];
  logic             slot_taken[W];

  logic [NUM_THREADS-1:0] handled_q;
  logic [NUM_THREADS-1:0] ld_blk_live;
  assign ld_blk_live = ld_blk_i & ~handled_q;

  for (genvar s = 0; s < W; s++) begin : g_slot
    assign slot_tid[s] = ex_tid_i[s*TID_W +: TID_W];
    assign slot_seq[s] = ex_seq_i[s*SEQ_W +: SEQ_W];
    assign slot_pc[s]  = ex_pc_i [s*PC_W  +: PC_W];
    assign slot_npc[s] = ex_npc_i[s*PC_W  +: PC_W];

    exr_slot_decode #(
      .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES)
    ) u_dec (
      .valid_i      (ex_valid_i[s]),
      .squashed_i   (ex_squashed_i[s]),
      .mem_i        (ex_mem_i[s]),
      .mispred_i    (ex_mispred_i[s]),
      .tid_i        (slot_tid[s]),
      .pc_i         (slot_pc[s]),
      .npc_i        (slot_npc[s]),
      .order_viol_i (order_viol_i),
      .ld_blk_live_i(ld_blk_live),
      .cause_o      (slot_cause[s]),
      .dir_taken_o  (slot_taken[s])
    );
  end

  logic             thr_hit [NUM_THREADS];
  logic [IDX_W-1:0] thr_idx [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pick
    exr_thread_pick #(.W(W), .TID_W(TID_W), .THREAD_ID(t)) u_pick (
      .cause_i(slot_cause),
      .tid_i  (slot_tid),
      .hit_o  (thr_hit[t]),
      .idx_o  (thr_idx[t])
    );
  end

  // next record per thread
  cause_e           nx_cause [NUM_THREADS];
  logic [SEQ_W-1:0] nx_seq   [NUM_THREADS];
  logic [PC_W-1:0]  nx_rst_pc[NUM_THREADS];
  logic [PC_W-1:0]  nx_mispc [NUM_THREADS];
  logic             nx_taken [NUM_THREADS];
  logic [INC_W-1:0] inc_tk, inc_nt, inc_ord;

  always_comb begin
    inc_tk  = '0;
    inc_nt  = '0;
    inc_ord = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      nx_cause[t]  = CAUSE_NONE;
      nx_seq[t]    = '0;
      nx_rst_pc[t] = '0;
      nx_mispc[t]  = '0;
      nx_taken[t]  = 1'b0;
      if (thr_hit[t]) begin
        nx_cause[t] = slot_cause[thr_idx[t]];
        nx_seq[t]   = slot_seq[thr_idx[t]];
        nx_rst_pc[t] = (nx_cause[t] == CAUSE_LDBLK) ? slot_pc[thr_idx[t]]
                                                     : slot_npc[thr_idx[t]];
        if (nx_cause[t] == CAUSE_BRANCH) begin
          nx_mispc[t] = slot_pc[thr_idx[t]];
          nx_taken[t] = slot_taken[thr_idx[t]];
          if (ex_pred_taken_i[thr_idx[t]]) inc_tk = inc_tk + INC_W'(1);
          else                             inc_nt = inc_nt + INC_W'(1);
        end
        if (nx_cause[t] == CAUSE_ORDER) inc_ord = inc_ord + INC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_valid_o      <= '0;
      sq_cause_o      <= '0;
      sq_incl_self_o  <= '0;
      sq_taken_o      <= '0;
      sq_seq_o        <= '0;
      sq_restart_pc_o <= '0;
      sq_mispc_o      <= '0;
      ld_blk_ack_o    <= '0;
      handled_q       <= '0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        sq_valid_o[t]                   <= thr_hit[t];
        sq_cause_o[t*2 +: 2]            <= nx_cause[t];
        sq_incl_self_o[t]               <= (nx_cause[t] == CAUSE_LDBLK);
        sq_taken_o[t]                   <= nx_taken[t];
        sq_seq_o[t*SEQ_W +: SEQ_W]      <= nx_seq[t];
        sq_restart_pc_o[t*PC_W +: PC_W] <= nx_rst_pc[t];
        sq_mispc_o[t*PC_W +: PC_W]      <= nx_mispc[t];
        ld_blk_ack_o[t]                 <= (nx_cause[t] == CAUSE_LDBLK);
        // handled until the queue drops its flag
        if (!ld_blk_i[t])                     handled_q[t] <= 1'b0;
        else if (nx_cause[t] == CAUSE_LDBLK)  handled_q[t] <= 1'b1;
      end
    end
  end

  exr_evt_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt_tk (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_tk), .cnt_o(cnt_taken_bad_o));
  exr_evt_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt_nt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_nt), .cnt_o(cnt_nt_bad_o));
  exr_evt_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt_ord (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_ord), .cnt_o(cnt_order_o));

  // assertions
  p_cnt_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_valid_o == '0) |-> ($stable(cnt_taken_bad_o) && $stable(cnt_nt_bad_o)
                            && $stable(cnt_order_o)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    p_ack_is_ldblk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_blk_ack_o[t] |-> (sq_valid_o[t] && sq_cause_o[t*2 +: 2] == 2'd3 && sq_incl_self_o[t]));
    p_incl_only_ldblk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sq_valid_o[t] && sq_cause_o[t*2 +: 2] != 2'd3) |-> !sq_incl_self_o[t]);
    p_no_rehandle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_blk_ack_o[t] && ld_blk_i[t]) |=> !ld_blk_ack_o[t]);
    p_nottaken_fallthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sq_valid_o[t] && sq_cause_o[t*2 +: 2] == 2'd1 && !sq_taken_o[t]) |->
      (sq_restart_pc_o[t*PC_W +: PC_W] == sq_mispc_o[t*PC_W +: PC_W] + PC_W'(INST_BYTES)));
    p_idle_rec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sq_valid_o[t] |-> (sq_cause_o[t*2 +: 2] == 2'd0 && !ld_blk_ack_o[t]));
  end
endmodule

// File: tb/exec_redirect_gen_test.sv
module exec_redirect_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4, T = 2, TID_W = 1, SEQ_W = 16, PC_W = 32, CNT_W = 16;

  logic clk_i = 0, rst_ni = 0;
  logic [W-1:0] ex_valid_i, ex_squashed_i, ex_mem_i, ex_mispred_i, ex_pred_taken_i;
  logic [W*TID_W-1:0] ex_tid_i;
  logic [W*SEQ_W-1:0] ex_seq_i;
  logic [W*PC_W-1:0] ex_pc_i, ex_npc_i;
  logic [T-1:0] order_viol_i, ld_blk_i;
  logic [T-1:0] sq_valid_o, sq_incl_self_o, sq_taken_o, ld_blk_ack_o;
  logic [T*2-1:0] sq_cause_o;
  logic [T*SEQ_W-1:0] sq_seq_o;
  logic [T*PC_W-1:0] sq_restart_pc_o, sq_mispc_o;
  logic [CNT_W-1:0] cnt_taken_bad_o, cnt_nt_bad_o, cnt_order_o;

  int n_chk = 0, n_err = 0;
  int e_tk = 0, e_nt = 0, e_ord = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exec_redirect_gen uut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    ex_valid_i = '0; ex_squashed_i = '0; ex_mem_i = '0; ex_mispred_i = '0;
    ex_pred_taken_i = '0; ex_tid_i = '0; ex_seq_i = '0; ex_pc_i = '0; ex_npc_i = '0;
    order_viol_i = '0; ld_blk_i = '0;
  endtask

  task automatic put(input int s, input int tid, input int seq, input logic [31:0] pc,
                     input logic [31:0] npc, input bit mis, input bit pt, input bit mem);
    ex_valid_i[s] = 1'b1;
    ex_tid_i[s*TID_W +: TID_W] = TID_W'(tid);
    ex_seq_i[s*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    ex_pc_i[s*PC_W +: PC_W] = pc;
    ex_npc_i[s*PC_W +: PC_W] = npc;
    ex_mispred_i[s] = mis;
    ex_pred_taken_i[s] = pt;
    ex_mem_i[s] = mem;
  endtask

  // apply current inputs for one edge, sample at following negedge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_rec(input string req, input int t, input int cause, input int seq,
                         input logic [31:0] rpc, input logic [31:0] mpc, input bit incl, input bit tk);
    chk(req, "valid", sq_valid_o[t], 1);
    chk(req, "cause", sq_cause_o[t*2 +: 2], cause);
    chk(req, "seq", sq_seq_o[t*SEQ_W +: SEQ_W], seq);
    chk(req, "restart", sq_restart_pc_o[t*PC_W +: PC_W], rpc);
    chk(req, "mispc", sq_mispc_o[t*PC_W +: PC_W], mpc);
    chk(req, "incl", sq_incl_self_o[t], incl);
    chk(req, "taken", sq_taken_o[t], tk);
  endtask

  task automatic chk_cnt(input string req);
    chk(req, "cnt_taken_bad", cnt_taken_bad_o, e_tk);
    chk(req, "cnt_nt_bad", cnt_nt_bad_o, e_nt);
    chk(req, "cnt_order", cnt_order_o, e_ord);
  endtask

  task automatic t_reset();
    chk("R1", "valid", sq_valid_o, 0);
    chk("R1", "ack", ld_blk_ack_o, 0);
    chk_cnt("R1");
  endtask

  task automatic t_branch();
    clear_in();
    put(0, 1, 5, 32'h40, 32'h44, 0, 0, 0);
    put(1, 0, 7, 32'h100, 32'h200, 1, 0, 0);
    step(); e_nt++;
    chk_rec("R2", 0, 1, 7, 32'h200, 32'h100, 0, 1);
    chk("R9", "thread1 idle", sq_valid_o[1], 0);
    chk_cnt("R10");
    clear_in(); step();
    chk("R11", "one cycle", sq_valid_o, 0);
    put(2, 0, 8, 32'h300, 32'h304, 1, 1, 0);
    step(); e_tk++;
    chk_rec("R3", 0, 1, 8, 32'h304, 32'h300, 0, 0);
    chk_cnt("R10");
    clear_in();
  endtask

  task automatic t_order();
    clear_in();
    put(0, 1, 9, 32'h400, 32'h404, 0, 0, 1);
    put(1, 0, 10, 32'h410, 32'h414, 0, 0, 1);
    order_viol_i = 2'b10;
    step(); e_ord++;
    chk_rec("R4", 1, 2, 9, 32'h404, 0, 0, 0);
    chk("R4", "thread0 unaffected", sq_valid_o[0], 0);
    chk_cnt("R10");
    clear_in();
  endtask

  task automatic t_ldblk();
    clear_in();
    put(2, 0, 20, 32'h500, 32'h504, 0, 0, 1);
    ld_blk_i = 2'b01;
    step();
    chk_rec("R5", 0, 3, 20, 32'h500, 0, 1, 0);
    chk("R5", "ack", ld_blk_ack_o, 2'b01);
    chk_cnt("R10");
    put(0, 0, 21, 32'h510, 32'h514, 0, 0, 1);
    step();
    chk("R6", "held flag ignored", sq_valid_o, 0);
    chk("R5", "ack one cycle", ld_blk_ack_o, 0);
    clear_in(); step();
    put(1, 0, 22, 32'h520, 32'h524, 0, 0, 1);
    ld_blk_i = 2'b01;
    step();
    chk_rec("R6", 0, 3, 22, 32'h520, 0, 1, 0);
    chk("R6", "rearmed ack", ld_blk_ack_o, 2'b01);
    clear_in(); step();
  endtask

  task automatic t_priority();
    clear_in();
    put(0, 0, 30, 32'h600, 32'h700, 1, 1, 1);
    put(1, 1, 31, 32'h610, 32'h614, 0, 0, 1);
    order_viol_i = 2'b11; ld_blk_i = 2'b11;
    step(); e_tk++; e_ord++;
    chk_rec("R7", 0, 1, 30, 32'h700, 32'h600, 0, 1);
    chk_rec("R7", 1, 2, 31, 32'h614, 0, 0, 0);
    chk("R7", "no ack", ld_blk_ack_o, 0);
    chk_cnt("R10");
    clear_in(); step();
  endtask

  task automatic t_first();
    clear_in();
    put(0, 1, 40, 32'h800, 32'h804, 0, 0, 0);
    put(1, 0, 41, 32'h810, 32'h900, 1, 0, 0);
    put(2, 0, 42, 32'h820, 32'h920, 1, 0, 0);
    put(3, 1, 43, 32'h830, 32'h930, 1, 0, 0);
    step(); e_nt += 2;
    chk_rec("R8", 0, 1, 41, 32'h900, 32'h810, 0, 1);
    chk_rec("R8", 1, 1, 43, 32'h930, 32'h830, 0, 1);
    chk_cnt("R10");
    clear_in();
  endtask

  task automatic t_skip();
    clear_in();
    put(0, 0, 50, 32'ha00, 32'hb00, 1, 0, 0);
    ex_squashed_i[0] = 1'b1;
    put(1, 0, 51, 32'ha10, 32'hb10, 1, 0, 0);
    ex_valid_i[1] = 1'b0;
    put(2, 0, 52, 32'ha20, 32'hb20, 1, 0, 0);
    step(); e_nt++;
    chk_rec("R9", 0, 1, 52, 32'hb20, 32'ha20, 0, 1);
    clear_in();
    put(0, 1, 53, 32'ha30, 32'hb30, 1, 0, 1);
    ex_squashed_i = '1;
    order_viol_i = 2'b10;
    step();
    chk("R9", "all squashed", sq_valid_o, 0);
    chk_cnt("R10");
    clear_in();
  endtask

  task automatic t_quiet();
    clear_in();
    put(0, 0, 60, 32'hc00, 32'hc04, 0, 1, 1);
    put(1, 1, 61, 32'hc10, 32'hd00, 0, 0, 0);
    step();
    chk("R11", "no cause", sq_valid_o, 0);
    chk_cnt("R10");
    clear_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_branch();
    t_order();
    t_ldblk();
    t_priority();
    t_first();
    t_skip();
    t_quiet();
    finish_run();
  end
endmodule